// File: doc/BRIEF.md
# SD Card Bus Line and Clock Control

This block owns the physical state of an SD card bus: the card clock pin, the command line and up to eight data lines. A two-bit power state, loaded through a small register write port, decides whether the block holds every line high (off), pulls every line low (power-cycle, so that a card that has lost its supply is not back-powered through its pins), or releases the command and data lines to the transfer logic and runs the card clock (on).

A second register sets the card clock divider and the bus shape. The card clock is the kernel clock divided by twice a 10-bit value N, and N of zero passes the kernel clock through unchanged. A new N is adopted only when the card clock falls, so a change never produces a shortened pulse. The same register selects the number of active data lanes (1, 4 or 8) and whether outgoing command and data bits should launch on the rising or the falling card clock edge; the block reports that choice as a level and as a one-cycle launch strobe.

Top module: `sdbus_line_ctrl`

## Requirements
- R1: After reset the power state is off, the lines are held high, the card clock pin is high, the width code is 0 (one lane), no lane is enabled, the launch strobe is low and N is 0.
- R2: A write with `wr_sel_i`=0 loads the power code from `wr_data_i[1:0]` at that clock edge: 2'b00 and 2'b01 give off, 2'b10 gives power-cycle, 2'b11 gives on; the new state is visible on the outputs from the next cycle.
- R3: In power-cycle, `pin_hold_o`=1, `pin_level_o`=0, the card clock pin is low, no lane is enabled and the strobe is low.
- R4: In power-off, `pin_hold_o`=1, `pin_level_o`=1 and the card clock pin is high.
- R5: A write of 2'b11 while in power-cycle is ignored: the state stays power-cycle; on is reachable only through off.
- R6: In the on state with N>0 the card clock starts low on entry and then alternates low and high phases of exactly N kernel cycles each.
- R7: In the on state with N=0 the card clock pin equals the kernel clock.
- R8: A write with `wr_sel_i`=1 loads N from `wr_data_i[9:0]`, but the divider adopts the stored N only at a falling card clock transition (or while the clock is not running), so the phase in progress and the following high phase keep the old length.
- R9: `wr_data_i[15]` selects eight lanes (width code 2), else `wr_data_i[14]` selects four lanes (code 1), else one lane (code 0); in the on state `lane_en_o` enables lanes 0 up to the selected count, and outside it no lane is enabled.
- R10: `wr_data_i[16]`=1 selects falling-edge launch (`fall_edge_o`=1); in the on state `out_stb_o` is high for the kernel cycle that begins with the selected card clock transition, and for every cycle while N=0.
- R11: In the on state `pin_hold_o`=0, releasing the command and data lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the power register, 1 the clock register |
| wr_data_i | input | 17 | Write data |
| card_clk_o | output | 1 | Card clock pin |
| pin_hold_o | output | 1 | 1 when the block itself drives the command and data lines |
| pin_level_o | output | 1 | Level driven on the held lines (1 off, 0 power-cycle) |
| lane_en_o | output | LANES | Data lanes released to the transfer logic |
| width_code_o | output | 2 | Bus width code: 0 one, 1 four, 2 eight lanes |
| fall_edge_o | output | 1 | 1 when bits launch on the falling card clock edge |
| out_stb_o | output | 1 | One-cycle pulse at each launch edge of the card clock |

## Verification
The risky coincidence is a clock register write landing on the very edge where the card clock falls: the divider must adopt the value stored before that edge, and the launch strobe must use the edge selection in force before the write. The bench provokes it by rewriting N and the edge bit at several phases of a running divided clock, including bypass entry and exit, and judges every cycle against a reference model that counts remaining phase cycles. A second coincidence, a power write arriving while the divider is mid-phase, is exercised by leaving the on state with the clock high and checking that the pin follows the new state at once.

// File: rtl/sdbus_pkg.sv
package sdbus_pkg;

    // Power state codes as written by software; 2'b01 is treated as off.
    typedef enum logic [1:0] {
        PWR_OFF = 2'b00,
        PWR_CYC = 2'b10,
        PWR_ON  = 2'b11
    } pwr_state_e;

    // Clock register field positions.
    localparam int unsigned WIDE4_BIT = 14;
    localparam int unsigned WIDE8_BIT = 15;
    localparam int unsigned FALL_BIT  = 16;
    localparam int unsigned WR_W      = FALL_BIT + 1;

    // Bus width codes.
    localparam logic [1:0] WIDTH_X1 = 2'd0;
    localparam logic [1:0] WIDTH_X4 = 2'd1;
    localparam logic [1:0] WIDTH_X8 = 2'd2;

endpackage

// File: rtl/sdbus_pwr_fsm.sv
module sdbus_pwr_fsm
    import sdbus_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic [1:0] code_i,
    output pwr_state_e state_o,
    output logic       on_next_o
);

    typedef struct packed {
        pwr_state_e st;
    } pwr_regs_t;

    pwr_regs_t q, d;

    always_comb begin
        d = q;
        if (wr_i) begin
            unique case (code_i)
                2'b11: begin
                    // on is only reachable from off or on
                    if (q.st != PWR_CYC) begin
                        d.st = PWR_ON;
                    end
                end
                2'b10:   d.st = PWR_CYC;
                default: d.st = PWR_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st <= PWR_OFF;
        end else begin
            q <= d;
        end
    end

    assign state_o   = q.st;
    assign on_next_o = (d.st == PWR_ON);

endmodule

// File: rtl/sdbus_cfg.sv
module sdbus_cfg
    import sdbus_pkg::*;
#(
    parameter int unsigned DIV_W = 10,
    parameter int unsigned LANES = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [WR_W-1:0]  data_i,
    input  logic             on_i,
    output logic [DIV_W-1:0] div_req_o,
    output logic [1:0]       width_o,
    output logic             fall_o,
    output logic [LANES-1:0] lane_en_o
);

    localparam int unsigned CNT_W = $clog2(LANES + 1);
    localparam int unsigned L4    = (LANES < 4) ? LANES : 4;
    localparam int unsigned L8    = (LANES < 8) ? LANES : 8;

    typedef struct packed {
        logic [DIV_W-1:0] nreq;
        logic             w4;
        logic             w8;
        logic             fall;
    } cfg_regs_t;

    cfg_regs_t        q, d;
    logic [CNT_W-1:0] act_cnt;
    logic             unused_bits;

    assign unused_bits = ^data_i[WIDE4_BIT-1:DIV_W];

    always_comb begin
        d = q;
        if (wr_i) begin
            d.nreq = data_i[DIV_W-1:0];
            d.w4   = data_i[WIDE4_BIT];
            d.w8   = data_i[WIDE8_BIT];
            d.fall = data_i[FALL_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // eight lanes wins when both width bits are set
    always_comb begin
        if (q.w8) begin
            width_o = WIDTH_X8;
            act_cnt = CNT_W'(L8);
        end else if (q.w4) begin
            width_o = WIDTH_X4;
            act_cnt = CNT_W'(L4);
        end else begin
            width_o = WIDTH_X1;
            act_cnt = CNT_W'(1);
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en_o[i] = on_i && (act_cnt > CNT_W'(i));
    end

    assign div_req_o = q.nreq;
    assign fall_o    = q.fall;

endmodule

// File: rtl/sdbus_clk_div.sv
module sdbus_clk_div #(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             on_i,
    input  logic             on_next_i,
    input  logic [DIV_W-1:0] div_req_i,
    input  logic             fall_i,
    output logic             run_clk_o,
    output logic             stb_o
);

    typedef struct packed {
        logic             lvl;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] nact;
        logic             stb;
    } div_regs_t;

    div_regs_t q, d;
    logic      tog;

    always_comb begin
        d   = q;
        tog = 1'b0;
        if (!on_i || (q.nact == '0)) begin
            // idle or bypass: hold low, adopt the request freely
            d.lvl  = 1'b0;
            d.cnt  = '0;
            d.nact = div_req_i;
        end else if (q.cnt == (q.nact - DIV_W'(1))) begin
            d.cnt = '0;
            d.lvl = ~q.lvl;
            tog   = 1'b1;
            if (q.lvl) begin
                // falling transition: start of a low phase
                d.nact = div_req_i;
            end
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
        d.stb = on_next_i && ((d.nact == '0) || (tog && (d.lvl != fall_i)));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_clk_o = (q.nact == '0) ? clk_i : q.lvl;
    assign stb_o     = q.stb;

endmodule

// File: rtl/sdbus_line_ctrl.sv
module sdbus_line_ctrl
    import sdbus_pkg::*;
#(
    parameter int unsigned DIV_W = 10,
    parameter int unsigned LANES = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [WR_W-1:0]  wr_data_i,
    output logic             card_clk_o,
    output logic             pin_hold_o,
    output logic             pin_level_o,
    output logic [LANES-1:0] lane_en_o,
    output logic [1:0]       width_code_o,
    output logic             fall_edge_o,
    output logic             out_stb_o
);

    pwr_state_e       st;
    logic             on_next;
    logic             is_on;
    logic [DIV_W-1:0] div_req;
    logic             fall_sel;
    logic             run_clk;

    sdbus_pwr_fsm u_pwr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_en_i && !wr_sel_i),
        .code_i    (wr_data_i[1:0]),
        .state_o   (st),
        .on_next_o (on_next)
    );

    assign is_on = (st == PWR_ON);

    sdbus_cfg #(
        .DIV_W (DIV_W),
        .LANES (LANES)
    ) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_en_i && wr_sel_i),
        .data_i    (wr_data_i),
        .on_i      (is_on),
        .div_req_o (div_req),
        .width_o   (width_code_o),
        .fall_o    (fall_sel),
        .lane_en_o (lane_en_o)
    );

    sdbus_clk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .on_i      (is_on),
        .on_next_i (on_next),
        .div_req_i (div_req),
        .fall_i    (fall_sel),
        .run_clk_o (run_clk),
        .stb_o     (out_stb_o)
    );

    always_comb begin
        unique case (st)
            PWR_ON:  card_clk_o = run_clk;
            PWR_CYC: card_clk_o = 1'b0;
            default: card_clk_o = 1'b1;
        endcase
    end

    assign pin_hold_o  = !is_on;
    assign pin_level_o = (st == PWR_OFF);
    assign fall_edge_o = fall_sel;

endmodule

// File: rtl/sdbus_line_ctrl_chk.sv
module sdbus_line_ctrl_chk #(
    parameter int unsigned LANES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             card_clk_o,
    input logic             pin_hold_o,
    input logic             pin_level_o,
    input logic [LANES-1:0] lane_en_o,
    input logic [1:0]       width_code_o,
    input logic             out_stb_o
);

    AST_CYC_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_hold_o && !pin_level_o) |-> (!card_clk_o && (lane_en_o == '0) && !out_stb_o)); // R3

    AST_OFF_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_hold_o && pin_level_o) |-> card_clk_o); // R4

    AST_CYC_NOT_TO_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_hold_o && !pin_level_o) |=> pin_hold_o); // R5

    AST_LANE0_WHEN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pin_hold_o |-> lane_en_o[0]); // R9

    AST_WIDTH_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        width_code_o != 2'b11); // R9

    AST_STB_ONLY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_stb_o |-> !pin_hold_o); // R10

endmodule

bind sdbus_line_ctrl sdbus_line_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .card_clk_o   (card_clk_o),
    .pin_hold_o   (pin_hold_o),
    .pin_level_o  (pin_level_o),
    .lane_en_o    (lane_en_o),
    .width_code_o (width_code_o),
    .out_stb_o    (out_stb_o)
);

// File: tb/sdbus_line_ctrl_test.sv
module sdbus_line_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int LANES      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [16:0]      wr_data = '0;
    logic             card_clk;
    logic             pin_hold;
    logic             pin_level;
    logic [LANES-1:0] lane_en;
    logic [1:0]       width_code;
    logic             fall_edge;
    logic             out_stb;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string clk_tag = "R6";

    // reference model state
    int m_ps = 0;      // 0 off, 2 power-cycle, 3 on
    int m_nreq = 0;
    int m_nact = 0;
    int m_left = 0;    // kernel cycles left in the current card clock phase
    int m_lvl = 0;
    int m_stb = 0;
    int m_w4 = 0;
    int m_w8 = 0;
    int m_fall = 0;

    sdbus_line_ctrl #(.DIV_W(10), .LANES(LANES)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .card_clk_o   (card_clk),
        .pin_hold_o   (pin_hold),
        .pin_level_o  (pin_level),
        .lane_en_o    (lane_en),
        .width_code_o (width_code),
        .fall_edge_o  (fall_edge),
        .out_stb_o    (out_stb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [16:0] clk_word(input int n, input bit w4, input bit w8, input bit fall);
        return 17'(n) | (17'(w4) << 14) | (17'(w8) << 15) | (17'(fall) << 16);
    endfunction

    // behavioural reference, advanced at every rising kernel clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ps = 0; m_nreq = 0; m_nact = 0; m_left = 0; m_lvl = 0;
            m_stb = 0; m_w4 = 0; m_w8 = 0; m_fall = 0;
        end else begin
            int nps;
            bit tog;
            nps = m_ps;
            if (wr_en && !wr_sel) begin
                if (wr_data[1:0] == 2'b11) begin
                    if (m_ps != 2) nps = 3;
                end else if (wr_data[1:0] == 2'b10) begin
                    nps = 2;
                end else begin
                    nps = 0;
                end
            end
            tog = 0;
            if (m_ps != 3 || m_nact == 0) begin
                m_lvl = 0;
                m_nact = m_nreq;
                m_left = m_nreq;
            end else if (m_left == 1) begin
                m_lvl = 1 - m_lvl;
                tog = 1;
                if (m_lvl == 0) m_nact = m_nreq;
                m_left = m_nact;
            end else begin
                m_left = m_left - 1;
            end
            m_stb = (nps == 3 && (m_nact == 0 || (tog && m_lvl != m_fall))) ? 1 : 0;
            m_ps = nps;
            if (wr_en && wr_sel) begin
                m_nreq = int'(wr_data[9:0]);
                m_w4 = int'(wr_data[14]);
                m_w8 = int'(wr_data[15]);
                m_fall = int'(wr_data[16]);
            end
        end
    end

    function automatic int exp_clk(input bit kclk);
        if (m_ps == 0) return 1;
        if (m_ps == 2) return 0;
        if (m_nact == 0) return int'(kclk);
        return m_lvl;
    endfunction

    function automatic string clk_req();
        if (m_ps == 0) return "R4";
        if (m_ps == 2) return "R3";
        if (m_nact == 0) return "R7";
        return clk_tag;
    endfunction

    task automatic compare_all(input bit kclk);
        int cnt;
        int mask;
        chk(clk_req(), "card_clk", int'(card_clk), exp_clk(kclk));
        if (!kclk) begin
            chk(m_ps == 3 ? "R11" : "R2", "pin_hold", int'(pin_hold), m_ps != 3 ? 1 : 0);
            chk("R2", "pin_level", int'(pin_level), m_ps == 0 ? 1 : 0);
            chk("R9", "width_code", int'(width_code), m_w8 ? 2 : (m_w4 ? 1 : 0));
            cnt = m_w8 ? 8 : (m_w4 ? 4 : 1);
            mask = (m_ps == 3) ? ((1 << cnt) - 1) : 0;
            chk("R9", "lane_en", int'(lane_en), mask);
            chk("R10", "fall_edge", int'(fall_edge), m_fall);
            chk("R10", "out_stb", int'(out_stb), m_stb);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) compare_all(1'b1);
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) compare_all(1'b0);
    end

    task automatic wr_reg(input bit sel, input logic [16:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state seen at the ports while reset is held
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset card_clk", int'(card_clk), 1);
        chk("R1", "reset pin_hold", int'(pin_hold), 1);
        chk("R1", "reset pin_level", int'(pin_level), 1);
        chk("R1", "reset width", int'(width_code), 0);
        chk("R1", "reset lanes", int'(lane_en), 0);
        chk("R1", "reset stb", int'(out_stb), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // R6, R9, R10, R11: divide by 6, four lanes, rising launch
        wr_reg(1'b1, clk_word(3, 1, 0, 0));
        wr_reg(1'b0, 17'd3);
        idle(40);

        // R8: new N written at several phase positions
        clk_tag = "R8";
        wr_reg(1'b1, clk_word(5, 1, 0, 0));
        idle(7);
        wr_reg(1'b1, clk_word(2, 1, 0, 0));
        idle(3);
        wr_reg(1'b1, clk_word(4, 1, 0, 0));
        idle(40);
        for (int k = 0; k < 6; k++) begin
            wr_reg(1'b1, clk_word(1 + k % 3, 0, 1, k % 2));
            idle(k + 1);
        end
        clk_tag = "R6";

        // R9, R10: both width bits set selects eight, falling launch
        wr_reg(1'b1, clk_word(3, 1, 1, 1));
        idle(30);

        // R7: bypass, then back to division
        wr_reg(1'b1, clk_word(0, 0, 0, 0));
        idle(20);
        wr_reg(1'b1, clk_word(2, 0, 1, 0));
        idle(20);

        // R3: power-cycle from on, with the clock possibly high
        wr_reg(1'b0, 17'd2);
        idle(10);

        // R5: on request ignored while in power-cycle
        wr_reg(1'b0, 17'd3);
        #1;
        chk("R5", "hold after on in cycle", int'(pin_hold), 1);
        chk("R5", "level after on in cycle", int'(pin_level), 0);
        idle(5);

        // R2, R4: reserved code 01 behaves as off
        wr_reg(1'b0, 17'd1);
        #1;
        chk("R4", "off level", int'(pin_level), 1);
        chk("R4", "off clock pin", int'(card_clk), 1);
        idle(5);

        // R6: N=1 from off to on, divide by two
        wr_reg(1'b1, clk_word(1, 0, 0, 1));
        wr_reg(1'b0, 17'd3);
        #1;
        chk("R11", "released in on", int'(pin_hold), 0);
        idle(20);

        // bypass entered straight from off
        wr_reg(1'b0, 17'd0);
        wr_reg(1'b1, clk_word(0, 1, 0, 1));
        wr_reg(1'b0, 17'd3);
        idle(10);
        wr_reg(1'b0, 17'd0);
        idle(5);

        finish_run();
    end

endmodule